// File: doc/BRIEF.md
# Idle-locked LFSR scrambler and descrambler

This block holds both ends of a bit-serial line scrambler. On the transmit side every encoded bit that arrives with a valid strobe is XORed with the output of an 11-bit linear feedback shift register (polynomial x^11 + x^9 + 1). The register runs freely and steps once per valid bit. It pays no attention to frame, byte or symbol boundaries. On the receive side a second register of the same shape produces the keystream that undoes the scrambling.

The receiver needs no shared reset and no frame alignment with the far end. Between frames the far end sends all-ones idle symbols, so the line then carries the inverted keystream. The receiver shifts the inverted line bits into its register for 11 valid bits. It then checks that the next 60 recovered bits are all ones, and only then reports lock. While locked and outside a frame, it counts zeros in fixed 30-bit blocks. A block with too many zeros drops lock and restarts the acquisition.

A bypass input turns both directions into plain pass-through, for links that carry unscrambled bits.

Top module: `idle_lock_scrambler`

## Requirements
- R1: While rst_n is low and in the first cycle after it, line_valid_o, rx_out_valid and rx_locked are 0.
- R2: The transmit keystream bit is k = s[10] ^ s[8], where s is an 11-bit state with s[0] the newest bit. The state resets to all ones and on each tx_valid becomes {s[9:0], k}. On the clock edge where tx_valid is 1, line_bit_o takes tx_bit ^ k and line_valid_o takes tx_valid.
- R3: The transmit state never becomes all zeros, and for constant input the scrambled line sequence repeats with a period of 2047 bits.
- R4: When out of lock, the receiver shifts the inverse of rx_bit into its state on each of 11 valid bits and then verifies 60 further valid bits. If every one of those descrambles to 1, rx_locked rises on the edge of the 71st valid idle bit and not before. Lock changes only on an edge where rx_valid is 1.
- R5: During verification, a descrambled 0 (or an all-zero receive state) sends the receiver back to a fresh 11-bit load. A full 71 further valid idle bits are then needed for lock.
- R6: On each rx_valid, rx_out_bit takes rx_bit ^ (receive keystream bit) one cycle later and rx_out_valid follows rx_valid. After lock, the output equals the transmitted data for any starting offset between the two registers.
- R7: While locked, bits received with frame_active low are counted in blocks of 30 valid bits. A block holding more than 4 descrambled zeros drops rx_locked at the edge of its 30th bit.
- R8: A block with 4 or fewer zeros keeps lock. A valid bit that arrives with frame_active high is not counted and restarts the block, so lock never drops during a frame.
- R9: With bypass high, line_bit_o takes tx_bit unchanged, rx_out_bit takes rx_bit unchanged, and rx_locked reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bypass | input | 1 | 1 = pass bits through without scrambling |
| tx_valid | input | 1 | Transmit bit strobe |
| tx_bit | input | 1 | Encoded bit to scramble |
| line_valid_o | output | 1 | Scrambled bit valid |
| line_bit_o | output | 1 | Scrambled line bit |
| rx_valid | input | 1 | Received bit strobe |
| rx_bit | input | 1 | Scrambled bit from the line |
| frame_active | input | 1 | 1 while a frame is being received |
| rx_out_valid | output | 1 | Descrambled bit valid |
| rx_out_bit | output | 1 | Descrambled bit |
| rx_locked | output | 1 | Receiver keystream is synchronized |

## Verification
The hardest case to reach is the exact zero-count boundary of the lock-loss block. Only the receiver knows where a block starts, so the stimulus sends one bit with frame_active high to restart the block at a known bit. It then loops scrambled data back with exactly 4 zeros, and next with 5 zeros, placed in the 30 counted bits. A second hard case is a zero in the middle of verification. The stimulus puts a single 0 data bit 21 bits into verification and shows that lock needs a full fresh 71 bits after it. Lock is also acquired after the transmitter has run an arbitrary number of bits ahead of the receiver.

// File: rtl/scr_pkg.sv
// Shared types for the idle-locked scrambler pair.
// Assumes nothing beyond IEEE 1800-2017 packages.
package scr_pkg;

    // Receive synchronizer phases: load keystream, verify it, run locked.
    typedef enum logic [1:0] {
        SYNC_LOAD   = 2'd0,
        SYNC_VERIFY = 2'd1,
        SYNC_LOCKED = 2'd2
    } sync_state_e;

    // Bits needed for a counter that reaches maxv.
    function automatic int unsigned cnt_bits(input int unsigned maxv);
        return $clog2(maxv + 1);
    endfunction

endpackage

// File: rtl/scr_lfsr.sv
// Fibonacci LFSR keystream generator.
// Key bit = state[WIDTH-1] ^ state[TAP-1]. On adv the state shifts left and
// takes either the key bit (free run) or load_bit (load mode).
// Assumes SEED is nonzero and TAP < WIDTH.
module scr_lfsr #(
    parameter int unsigned       WIDTH = 11,
    parameter int unsigned       TAP   = 9,
    parameter logic [WIDTH-1:0]  SEED  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             load,
    input  logic             load_bit,
    output logic             key,
    output logic [WIDTH-1:0] state_o
);

    logic [WIDTH-1:0] state;
    logic             shift_in;

    generate
        if (TAP >= WIDTH || TAP == 0) begin : g_bad_tap
            initial $display("scr_lfsr: TAP must lie in 1..WIDTH-1");
        end
    endgenerate

    // Feedback bit from the two taps.
    assign key      = state[WIDTH-1] ^ state[TAP-1];
    // Pick the bit that enters the register.
    assign shift_in = load ? load_bit : key;
    assign state_o  = state;

    // Shift the register once per advance strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED;
        end else if (adv) begin
            state <= {state[WIDTH-2:0], shift_in};
        end
    end

endmodule

// File: rtl/scr_tx_path.sv
// Transmit scrambler: XORs each valid bit with a free-running keystream,
// or passes it through when bypass is high. Output is registered.
// Assumes the keystream steps only on valid bits.
module scr_tx_path #(
    parameter int unsigned       WIDTH = 11,
    parameter int unsigned       TAP   = 9,
    parameter logic [WIDTH-1:0]  SEED  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass,
    input  logic             bit_valid,
    input  logic             bit_in,
    output logic             line_valid,
    output logic             line_bit,
    output logic [WIDTH-1:0] key_state
);

    logic key;

    scr_lfsr #(.WIDTH(WIDTH), .TAP(TAP), .SEED(SEED)) u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (bit_valid),
        .load     (1'b0),
        .load_bit (1'b0),
        .key      (key),
        .state_o  (key_state)
    );

    // Register the scrambled (or raw) bit and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_valid <= 1'b0;
            line_bit   <= 1'b0;
        end else begin
            line_valid <= bit_valid;
            if (bit_valid) begin
                line_bit <= bypass ? bit_in : (bit_in ^ key);
            end
        end
    end

endmodule

// File: rtl/scr_rx_sync.sv
// Receive synchronizer. Out of lock it loads the inverted line bits into
// the receive LFSR, then checks LOCK_ONES consecutive descrambled ones.
// Locked, it counts zeros in blocks of WIN_LEN bits received outside a frame
// and drops lock when a block holds more than ZERO_MAX zeros.
// Assumes the far end sends all-ones idle between frames.
module scr_rx_sync
    import scr_pkg::*;
#(
    parameter int unsigned WIDTH     = 11,
    parameter int unsigned LOCK_ONES = 60,
    parameter int unsigned WIN_LEN   = 30,
    parameter int unsigned ZERO_MAX  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic rx_bit,
    input  logic key,
    input  logic key_state_zero,
    input  logic frame_active,
    output logic load_mode,
    output logic locked_o
);

    localparam int unsigned CNT_MAX = (LOCK_ONES > WIDTH) ? LOCK_ONES : WIDTH;
    localparam int unsigned CNT_W   = cnt_bits(CNT_MAX);
    localparam int unsigned WIN_W   = cnt_bits(WIN_LEN);
    localparam logic [CNT_W-1:0] LOAD_LAST   = CNT_W'(WIDTH - 1);
    localparam logic [CNT_W-1:0] VERIFY_LAST = CNT_W'(LOCK_ONES - 1);
    localparam logic [WIN_W-1:0] WIN_LAST    = WIN_W'(WIN_LEN - 1);
    localparam logic [WIN_W-1:0] ZC_LIMIT    = WIN_W'(ZERO_MAX);

    sync_state_e      st;
    logic [CNT_W-1:0] cnt;
    logic [WIN_W-1:0] win;
    logic [WIN_W-1:0] zc;
    logic [WIN_W-1:0] zc_next;
    logic             descr;

    // Descrambled bit and the zero count including it.
    assign descr   = rx_bit ^ key;
    assign zc_next = zc + {{(WIN_W-1){1'b0}}, ~descr};

    assign load_mode = (st == SYNC_LOAD);
    assign locked_o  = (st == SYNC_LOCKED);

    // Acquisition, verification and lock-monitoring sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= SYNC_LOAD;
            cnt <= '0;
            win <= '0;
            zc  <= '0;
        end else begin
            case (st)
                SYNC_LOAD: begin
                    if (bit_valid) begin
                        if (cnt == LOAD_LAST) begin
                            st  <= SYNC_VERIFY;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                SYNC_VERIFY: begin
                    if (bit_valid) begin
                        if (!descr || key_state_zero) begin
                            st  <= SYNC_LOAD;
                            cnt <= '0;
                        end else if (cnt == VERIFY_LAST) begin
                            st  <= SYNC_LOCKED;
                            cnt <= '0;
                            win <= '0;
                            zc  <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                SYNC_LOCKED: begin
                    if (frame_active) begin
                        win <= '0;
                        zc  <= '0;
                    end else if (bit_valid) begin
                        if (win == WIN_LAST) begin
                            win <= '0;
                            zc  <= '0;
                            if (zc_next > ZC_LIMIT) begin
                                st  <= SYNC_LOAD;
                                cnt <= '0;
                            end
                        end else begin
                            win <= win + 1'b1;
                            zc  <= zc_next;
                        end
                    end
                end
                default: begin
                    st  <= SYNC_LOAD;
                    cnt <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/idle_lock_scrambler.sv
// Top: transmit scrambler plus self-synchronizing receive descrambler.
// Both sides handle one bit per clock under a valid strobe. The receive
// keystream is recovered from scrambled all-ones idle; bypass passes bits
// through in both directions and reports lock.
module idle_lock_scrambler #(
    parameter int unsigned       WIDTH     = 11,
    parameter int unsigned       TAP       = 9,
    parameter logic [WIDTH-1:0]  SEED      = '1,
    parameter int unsigned       LOCK_ONES = 60,
    parameter int unsigned       WIN_LEN   = 30,
    parameter int unsigned       ZERO_MAX  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bypass,
    input  logic tx_valid,
    input  logic tx_bit,
    output logic line_valid_o,
    output logic line_bit_o,
    input  logic rx_valid,
    input  logic rx_bit,
    input  logic frame_active,
    output logic rx_out_valid,
    output logic rx_out_bit,
    output logic rx_locked
);

    logic [WIDTH-1:0] tx_state;
    logic [WIDTH-1:0] rx_state;
    logic             rx_key;
    logic             rx_load;
    logic             rx_lock_int;
    logic             rx_state_zero;

    scr_tx_path #(.WIDTH(WIDTH), .TAP(TAP), .SEED(SEED)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bypass     (bypass),
        .bit_valid  (tx_valid),
        .bit_in     (tx_bit),
        .line_valid (line_valid_o),
        .line_bit   (line_bit_o),
        .key_state  (tx_state)
    );

    scr_lfsr #(.WIDTH(WIDTH), .TAP(TAP), .SEED(SEED)) u_rx_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (rx_valid),
        .load     (rx_load),
        .load_bit (~rx_bit),
        .key      (rx_key),
        .state_o  (rx_state)
    );

    // Flag a receive state that could never produce a keystream.
    assign rx_state_zero = (rx_state == '0);

    scr_rx_sync #(
        .WIDTH(WIDTH), .LOCK_ONES(LOCK_ONES),
        .WIN_LEN(WIN_LEN), .ZERO_MAX(ZERO_MAX)
    ) u_sync (
        .clk            (clk),
        .rst_n          (rst_n),
        .bit_valid      (rx_valid),
        .rx_bit         (rx_bit),
        .key            (rx_key),
        .key_state_zero (rx_state_zero),
        .frame_active   (frame_active),
        .load_mode      (rx_load),
        .locked_o       (rx_lock_int)
    );

    // Register the descrambled (or raw) received bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_out_valid <= 1'b0;
            rx_out_bit   <= 1'b0;
        end else begin
            rx_out_valid <= rx_valid;
            if (rx_valid) begin
                rx_out_bit <= bypass ? rx_bit : (rx_bit ^ rx_key);
            end
        end
    end

    // Bypass needs no keystream, so it always reads as locked.
    assign rx_locked = bypass | rx_lock_int;

    logic unused_tx_state;
    assign unused_tx_state = ^tx_state;

endmodule

// File: rtl/scr_chk.sv
// Property checker for idle_lock_scrambler, attached with bind.
// Assumes synchronous active-low reset on rst_n.
module scr_chk #(
    parameter int unsigned WIDTH = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bypass,
    input logic             tx_valid,
    input logic             tx_bit,
    input logic             line_valid_o,
    input logic             line_bit_o,
    input logic             rx_valid,
    input logic             frame_active,
    input logic             rx_out_valid,
    input logic [WIDTH-1:0] tx_state,
    input logic             lock_q
);

    AST_TX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> line_valid_o);                                   // R2

    AST_TX_STATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tx_state != '0);                                               // R3

    AST_LOCK_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(rx_valid));                            // R4

    AST_LOCK_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(lock_q));                                // R4

    AST_RX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> rx_out_valid);                                    // R6

    AST_FRAME_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && frame_active) |=> lock_q);                          // R8

    AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && tx_valid) |=> (line_bit_o == $past(tx_bit)));       // R9

endmodule

bind idle_lock_scrambler scr_chk #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bypass       (bypass),
    .tx_valid     (tx_valid),
    .tx_bit       (tx_bit),
    .line_valid_o (line_valid_o),
    .line_bit_o   (line_bit_o),
    .rx_valid     (rx_valid),
    .frame_active (frame_active),
    .rx_out_valid (rx_out_valid),
    .tx_state     (u_tx.key_state),
    .lock_q       (u_sync.locked_o)
);

// File: tb/tb_idle_lock_scrambler.sv
module tb_idle_lock_scrambler;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bypass = 1'b0;
    logic tx_valid = 1'b0;
    logic tx_bit = 1'b0;
    logic rx_valid = 1'b0;
    logic rx_bit = 1'b0;
    logic frame_active = 1'b0;
    logic line_valid_o, line_bit_o, rx_out_valid, rx_out_bit, rx_locked;

    int   n_vec = 0;
    int   n_bad = 0;
    logic done = 1'b0;

    // Bench state for the loopback.
    logic        rx_en = 1'b0;
    logic        last_line = 1'b0;
    logic        prev_d = 1'b1;
    logic        prev_byp = 1'b0;
    logic        rx_src_d;
    logic [10:0] ref_s = 11'h7FF;
    logic [63:0] first_bits;

    // Stimulus table: {bypass, 16-bit data word sent msb first}.
    localparam logic [16:0] VEC [8] = '{
        17'h0_A5C3, 17'h0_0000, 17'h0_FFFF, 17'h0_1234,
        17'h0_8001, 17'h1_F0F0, 17'h1_0F0F, 17'h1_6996
    };

    idle_lock_scrambler dut (
        .clk(clk), .rst_n(rst_n), .bypass(bypass),
        .tx_valid(tx_valid), .tx_bit(tx_bit),
        .line_valid_o(line_valid_o), .line_bit_o(line_bit_o),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .frame_active(frame_active),
        .rx_out_valid(rx_out_valid), .rx_out_bit(rx_out_bit),
        .rx_locked(rx_locked)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // One bit in each direction: tx gets d, rx gets the previous line bit.
    task automatic step(input logic d, input logic fa);
        logic k;
        logic exp_line;
        k        = ref_s[10] ^ ref_s[8];
        exp_line = bypass ? d : (d ^ k);
        ref_s    = {ref_s[9:0], k};
        tx_valid = 1'b1;
        tx_bit   = d;
        rx_valid = rx_en;
        rx_bit   = last_line;
        frame_active = fa;
        rx_src_d = prev_d;
        prev_d   = d;
        @(negedge clk);
        last_line = line_bit_o;
        chk(bypass ? "R9 line" : "R2 line", {31'd0, line_bit_o}, {31'd0, exp_line});
    endtask

    // Zero-count block: 30 counted bits with zeros where zpos says.
    task automatic window(input int period, input int zmax_pos, input logic exp_lock, input string tag);
        for (int i = 0; i < 30; i++) begin
            step(((i % period) == 2 && i < zmax_pos) ? 1'b0 : 1'b1, (i == 0));
            if (i > 0) chk("R6 window data", {31'd0, rx_out_bit}, {31'd0, rx_src_d});
        end
        step(1'b1, 1'b0);
        chk(tag, {31'd0, rx_locked}, {31'd0, exp_lock});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 line_valid in reset", {31'd0, line_valid_o}, 32'd0);
        chk("R1 rx_out_valid in reset", {31'd0, rx_out_valid}, 32'd0);
        chk("R1 locked in reset", {31'd0, rx_locked}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 line_valid after reset", {31'd0, line_valid_o}, 32'd0);
        chk("R1 locked after reset", {31'd0, rx_locked}, 32'd0);

        // Transmitter runs ahead of the receiver: arbitrary offset.
        for (int i = 0; i < 2100; i++) begin
            step(1'b1, 1'b0);
            if (i < 64) first_bits[i] = last_line;
            if (i >= 2047) chk("R3 period", {31'd0, last_line}, {31'd0, first_bits[i-2047]});
        end

        // Acquisition from idle.
        rx_en = 1'b1;
        for (int i = 0; i < 70; i++) step(1'b1, 1'b0);
        chk("R4 not locked after 70", {31'd0, rx_locked}, 32'd0);
        step(1'b1, 1'b0);
        chk("R4 locked after 71", {31'd0, rx_locked}, 32'd1);
        chk("R6 rx_out_valid", {31'd0, rx_out_valid}, 32'd1);

        // Table walk: scrambled frames then bypass words.
        for (int v = 0; v < 8; v++) begin
            bypass = VEC[v][16];
            for (int b = 15; b >= 0; b--) begin
                step(VEC[v][b], 1'b1);
                if (bypass == prev_byp)
                    chk(bypass ? "R9 rx raw" : "R6 rx data", {31'd0, rx_out_bit}, {31'd0, rx_src_d});
                prev_byp = bypass;
                if (bypass) chk("R9 lock", {31'd0, rx_locked}, 32'd1);
            end
            if (v == 4) begin
                chk("R8 frame bits kept lock", {31'd0, rx_locked}, 32'd1);
                // Zero-count blocks outside a frame.
                window(7, 28, 1'b1, "R8 four zeros keep lock");
                window(6, 30, 1'b0, "R7 five zeros drop lock");
                // Verification interrupted by a single zero.
                for (int i = 0; i < 31; i++) step(1'b1, 1'b0);
                step(1'b0, 1'b0);
                step(1'b1, 1'b0);
                for (int i = 0; i < 70; i++) step(1'b1, 1'b0);
                chk("R5 zero restarted load", {31'd0, rx_locked}, 32'd0);
                step(1'b1, 1'b0);
                chk("R5 relock after fresh load", {31'd0, rx_locked}, 32'd1);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule